// File: doc/BRIEF.md
# Paper Tape Reader Controller

This block controls an eight-channel paper tape reader that sits on an 18-bit I/O bus. The processor talks to it through four command strobes, each high for one clock cycle: a flag test that answers with a skip request, a buffer read that puts the buffer on the return bus and clears the done flag, and a start. The start can be issued with or without a binary qualifier. The reader mechanism presents one frame at a time as an 8-bit value qualified by a one-cycle valid strobe. It also raises a level that means it has run out of tape.

A start without the qualifier reads one alphanumeric frame. A parity option can rewrite the top channel of that frame. A start with the binary qualifier assembles one 18-bit word from three frames that have channel 8 punched. Frames without that hole are skipped. When a read ends, the done flag rises; it serves as the interrupt request. An out-of-tape condition during a pending read ends the read with the error bit set.

Top module: `tape_rdr_ctl`

## Requirements
- R1: While `cmdTest` is high, `skipReq` is high exactly when the done flag is set.
- R2: While `cmdRead` is high, `busOut` carries the buffer zero-extended to 18 bits, and the done flag is clear from the next cycle on. When `cmdRead` is low, `busOut` is zero.
- R3: `cmdStart` clears the done flag, the buffer and the error bit, and begins a read. The read is binary if `cmdBinary` is high in the same cycle and alphanumeric otherwise.
- R4: In a binary read, a frame with bit 7 at 0 is dropped. It neither changes the buffer nor counts toward the word.
- R5: In a binary read, the low 6 bits of the accepted frames are packed into the word in arrival order: the first at bits 17:12, the second at 11:6 and the third at 5:0. The done flag rises only after the third accepted frame.
- R6: In an alphanumeric read, the first frame ends the read and sets the done flag. With `parityMode` 0 (and 3) the buffer takes all 8 bits unchanged.
- R7: With `parityMode` 1 (even), the buffer keeps frame bits 6:0 and sets bit 7 so that the 8-bit value has an even number of ones.
- R8: With `parityMode` 2 (forced), the buffer keeps frame bits 6:0 and sets bit 7 to 1.
- R9: `tapeOut` high while a read is pending sets both `flagDone` and `errBit`, which are reported on separate outputs. Only a start or reset clears the error bit.
- R10: A frame or `tapeOut` that arrives while no read is pending has no effect on the buffer, the flag or the error bit.
- R11: A start issued in the middle of a binary word throws away the partial word and the frame count.
- R12: Synchronous active-high `rst` clears the buffer, the flag, the error bit, the mode and the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdTest | input | 1 | Flag test strobe |
| cmdRead | input | 1 | Buffer read strobe; clears the flag |
| cmdStart | input | 1 | Start read strobe |
| cmdBinary | input | 1 | Mode qualifier for start: 1 binary, 0 alphanumeric |
| parityMode | input | 2 | Alphanumeric parity treatment: 0 pass, 1 even, 2 forced, 3 pass |
| frameValid | input | 1 | One-cycle strobe from the reader: a frame is present |
| frameData | input | 8 | Tape frame; bit 7 is channel 8 |
| tapeOut | input | 1 | Reader out-of-tape level |
| busOut | output | 18 | Data returned to the bus during a read strobe |
| skipReq | output | 1 | Skip request during a flag test |
| flagDone | output | 1 | Done flag / interrupt request |
| errBit | output | 1 | Out-of-tape error status |

## Verification
The alphanumeric path runs through a table of frames under each parity option. The table has frames with an odd and an even count of ones in bits 6:0, frames with bit 7 already set, and the all-zero and all-one frames. Together these show whether the parity bit is computed, forced or passed, and whether bit 7 of the input leaks through. Binary words are built from distinct 6-bit groups with rejected frames placed between them, which exposes swapped group slots, counted rejects and an early done. Directed cases cover out-of-tape with the reader busy and with it idle, stray frames, a restart in the middle of a word, and reset in the middle of a read.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;
  localparam int FRAME_W = 8;
  localparam int GRP_W   = 6;
  localparam int NGRP    = 3;
  localparam int WORD_W  = GRP_W * NGRP;
  localparam int IDX_W   = $clog2(NGRP);

  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_FORCE = 2'd2;

  typedef struct packed {
    logic             clrBuf;
    logic             loadAlpha;
    logic             loadGroup;
    logic [IDX_W-1:0] grpIdx;
    logic             rdEn;
  } strobe_t;
endpackage

// File: rtl/tape_rdr_dpath.sv
module tape_rdr_dpath
  import tape_rdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [1:0]         parityMode,
  input  logic [FRAME_W-1:0] frameData,
  output logic [WORD_W-1:0]  busOut
);
  logic [WORD_W-1:0]  bufReg;
  logic [WORD_W-1:0]  placed;
  logic [FRAME_W-1:0] alphaVal;

  // parity treatment of an alphanumeric frame
  always_comb begin
    case (parityMode)
      PAR_EVEN:  alphaVal = {^frameData[FRAME_W-2:0], frameData[FRAME_W-2:0]};
      PAR_FORCE: alphaVal = {1'b1, frameData[FRAME_W-2:0]};
      default:   alphaVal = frameData;
    endcase
  end

  // one slot per group, first group most significant
  for (genvar g = 0; g < NGRP; g++) begin : g_slot
    assign placed[WORD_W-1-g*GRP_W -: GRP_W] =
      (strb.grpIdx == IDX_W'(g)) ? frameData[GRP_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 bufReg <= '0;
    else if (strb.clrBuf)    bufReg <= '0;
    else if (strb.loadAlpha) bufReg <= WORD_W'(alphaVal);
    else if (strb.loadGroup) bufReg <= bufReg | placed;
  end

  assign busOut = strb.rdEn ? bufReg : '0;

  a_r8_forced_top: assert property (@(posedge clk) disable iff (rst)
    (strb.loadAlpha && !strb.clrBuf && parityMode == PAR_FORCE) |=> bufReg[FRAME_W-1]);
  a_r7_even_ones: assert property (@(posedge clk) disable iff (rst)
    (strb.loadAlpha && !strb.clrBuf && parityMode == PAR_EVEN) |=> !(^bufReg[FRAME_W-1:0]));
  a_r3_buf_cleared: assert property (@(posedge clk) disable iff (rst)
    strb.clrBuf |=> bufReg == '0);
endmodule

// File: rtl/tape_rdr_ctrl.sv
module tape_rdr_ctrl
  import tape_rdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmdTest,
  input  logic    cmdRead,
  input  logic    cmdStart,
  input  logic    cmdBinary,
  input  logic    frameValid,
  input  logic    chan8,
  input  logic    tapeOut,
  output strobe_t strb,
  output logic    skipReq,
  output logic    flagDone,
  output logic    errBit
);
  logic             pending;
  logic             isBin;
  logic [IDX_W-1:0] grpCnt;
  logic             frameTake;
  logic             lastGrp;

  assign frameTake = pending && frameValid && !cmdStart && !tapeOut;
  assign lastGrp   = (grpCnt == IDX_W'(NGRP-1));

  always_comb begin
    strb.clrBuf    = cmdStart;
    strb.loadAlpha = frameTake && !isBin;
    strb.loadGroup = frameTake && isBin && chan8;
    strb.grpIdx    = grpCnt;
    strb.rdEn      = cmdRead;
  end

  assign skipReq = cmdTest && flagDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      isBin    <= 1'b0;
      grpCnt   <= '0;
      flagDone <= 1'b0;
      errBit   <= 1'b0;
    end else begin
      if (cmdRead || cmdStart) flagDone <= 1'b0;
      if (cmdStart) begin
        pending <= 1'b1;
        isBin   <= cmdBinary;
        grpCnt  <= '0;
        errBit  <= 1'b0;
      end else if (pending && tapeOut) begin
        pending  <= 1'b0;
        flagDone <= 1'b1;
        errBit   <= 1'b1;
        grpCnt   <= '0;
      end else if (strb.loadAlpha) begin
        pending  <= 1'b0;
        flagDone <= 1'b1;
      end else if (strb.loadGroup) begin
        if (lastGrp) begin
          pending  <= 1'b0;
          flagDone <= 1'b1;
          grpCnt   <= '0;
        end else begin
          grpCnt <= grpCnt + 1'b1;
        end
      end
    end
  end

  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    cmdStart |=> (!flagDone && !errBit && pending));
  a_r2_read_clears_idle: assert property (@(posedge clk) disable iff (rst)
    (cmdRead && !pending && !cmdStart) |=> !flagDone);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    grpCnt < IDX_W'(NGRP));
  a_r5_done_on_last: assert property (@(posedge clk) disable iff (rst)
    (strb.loadGroup && lastGrp) |=> flagDone);
  a_r9_err_with_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(errBit) |-> flagDone);
  a_r10_idle_err_stable: assert property (@(posedge clk) disable iff (rst)
    (!pending && !cmdStart) |=> $stable(errBit));
endmodule

// File: rtl/tape_rdr_ctl.sv
module tape_rdr_ctl
  import tape_rdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdTest,
  input  logic               cmdRead,
  input  logic               cmdStart,
  input  logic               cmdBinary,
  input  logic [1:0]         parityMode,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               tapeOut,
  output logic [WORD_W-1:0]  busOut,
  output logic               skipReq,
  output logic               flagDone,
  output logic               errBit
);
  strobe_t strb;

  tape_rdr_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmdTest(cmdTest), .cmdRead(cmdRead), .cmdStart(cmdStart), .cmdBinary(cmdBinary),
    .frameValid(frameValid), .chan8(frameData[FRAME_W-1]), .tapeOut(tapeOut),
    .strb(strb), .skipReq(skipReq), .flagDone(flagDone), .errBit(errBit)
  );

  tape_rdr_dpath u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .parityMode(parityMode), .frameData(frameData), .busOut(busOut)
  );
endmodule

// File: tb/tape_rdr_ctl_tb.sv
module tape_rdr_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdTest = 0, cmdRead = 0, cmdStart = 0, cmdBinary = 0;
  logic [1:0]  parityMode = 0;
  logic        frameValid = 0;
  logic [7:0]  frameData = 0;
  logic        tapeOut = 0;
  logic [17:0] busOut;
  logic        skipReq, flagDone, errBit;

  int total = 0;
  int bad = 0;
  logic [17:0] lastBus;
  logic        lastSkip;

  tape_rdr_ctl u_dut (
    .clk(clk), .rst(rst), .cmdTest(cmdTest), .cmdRead(cmdRead), .cmdStart(cmdStart),
    .cmdBinary(cmdBinary), .parityMode(parityMode), .frameValid(frameValid),
    .frameData(frameData), .tapeOut(tapeOut), .busOut(busOut), .skipReq(skipReq),
    .flagDone(flagDone), .errBit(errBit)
  );

  always #4 clk = ~clk;

  // {parityMode[1:0], frame[7:0], expected[7:0]}
  localparam logic [17:0] ALPHA_VEC [10] = '{
    {2'd0, 8'h41, 8'h41}, {2'd0, 8'hC3, 8'hC3}, {2'd3, 8'h87, 8'h87},
    {2'd1, 8'h41, 8'h41}, {2'd1, 8'h43, 8'hC3}, {2'd1, 8'hFF, 8'hFF},
    {2'd1, 8'h80, 8'h00}, {2'd2, 8'h00, 8'h80}, {2'd2, 8'h7F, 8'hFF},
    {2'd2, 8'hC5, 8'hC5}
  };

  task automatic chk(input logic ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic t, input logic r, input logic s, input logic b);
    @(negedge clk);
    cmdTest = t; cmdRead = r; cmdStart = s; cmdBinary = b;
    #1;
    lastBus = busOut;
    lastSkip = skipReq;
    @(negedge clk);
    cmdTest = 0; cmdRead = 0; cmdStart = 0; cmdBinary = 0;
  endtask

  task automatic frame(input logic [7:0] d);
    @(negedge clk);
    frameValid = 1; frameData = d;
    @(negedge clk);
    frameValid = 0; frameData = 8'h00;
  endtask

  task automatic pulseOut();
    @(negedge clk);
    tapeOut = 1;
    @(negedge clk);
    tapeOut = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(!flagDone && !errBit, "R12 reset flags", {16'b0, flagDone, errBit}, 18'h0);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h0, "R12 reset buffer", lastBus, 18'h0);
    cmd(1, 0, 0, 0);
    chk(!lastSkip, "R1 no skip when clear", {17'b0, lastSkip}, 18'h0);

    // R6 R7 R8 alpha table
    foreach (ALPHA_VEC[i]) begin
      parityMode = ALPHA_VEC[i][17:16];
      cmd(0, 0, 1, 0);
      chk(!flagDone, "R3 start clears flag", {17'b0, flagDone}, 18'h0);
      frame(ALPHA_VEC[i][15:8]);
      chk(flagDone, "R6 one frame sets flag", {17'b0, flagDone}, 18'h1);
      cmd(1, 0, 0, 0);
      chk(lastSkip, "R1 skip when done", {17'b0, lastSkip}, 18'h1);
      cmd(0, 1, 0, 0);
      chk(lastBus == {10'b0, ALPHA_VEC[i][7:0]}, "R6/R7/R8 alpha value",
          lastBus, {10'b0, ALPHA_VEC[i][7:0]});
      chk(!flagDone, "R2 read clears flag", {17'b0, flagDone}, 18'h0);
    end
    parityMode = 0;

    // R10 frame while idle leaves buffer
    frame(8'h3C);
    chk(!flagDone, "R10 idle frame no flag", {17'b0, flagDone}, 18'h0);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h000C5, "R10 idle frame buffer", lastBus, 18'h000C5);

    // R4 R5 binary packing
    cmd(0, 0, 1, 1);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h0, "R3 start clears buffer", lastBus, 18'h0);
    frame(8'h85);
    frame(8'h05);
    frame(8'hBF);
    chk(!flagDone, "R5 no flag after two", {17'b0, flagDone}, 18'h0);
    frame(8'h7F);
    chk(!flagDone, "R4 reject not counted", {17'b0, flagDone}, 18'h0);
    frame(8'hC0);
    chk(flagDone, "R5 flag after third", {17'b0, flagDone}, 18'h1);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h05FC0, "R5 packed word", lastBus, 18'h05FC0);

    // R11 restart discards partial word
    cmd(0, 0, 1, 1);
    frame(8'hFF);
    frame(8'hBE);
    cmd(0, 0, 1, 1);
    frame(8'h81);
    frame(8'h82);
    frame(8'h83);
    chk(flagDone, "R11 flag after fresh three", {17'b0, flagDone}, 18'h1);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h01083, "R11 fresh word", lastBus, 18'h01083);

    // R9 out of tape while pending
    cmd(0, 0, 1, 0);
    pulseOut();
    chk(flagDone && errBit, "R9 tape out flags", {16'b0, flagDone, errBit}, 18'h3);
    cmd(0, 1, 0, 0);
    chk(!flagDone && errBit, "R9 err survives read", {16'b0, flagDone, errBit}, 18'h1);
    cmd(0, 0, 1, 0);
    chk(!errBit, "R3 start clears err", {17'b0, errBit}, 18'h0);
    frame(8'h21);
    cmd(0, 1, 0, 0);
    // R10 tape out while idle
    pulseOut();
    chk(!flagDone && !errBit, "R10 idle tape out", {16'b0, flagDone, errBit}, 18'h0);

    // R12 reset mid-read
    cmd(0, 0, 1, 1);
    frame(8'hAA);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    frame(8'h81);
    frame(8'h82);
    chk(!flagDone, "R12 reset drops read", {17'b0, flagDone}, 18'h0);
    cmd(0, 1, 0, 0);
    chk(lastBus == 18'h0, "R12 reset clears buffer", lastBus, 18'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule